// File: doc/BRIEF.md
# Periodic Interval Timer with Modulus Reload

This block is a 16-bit down-counting interval timer with a three-register interface: control/status, modulus and live count. A prescale counter divides the system clock by two and then by a power of two chosen by a 4-bit field. The counter steps down once per prescaled period. When a step is taken from zero, an interrupt flag is set and the counter restarts. It restarts from the modulus register in reload mode and from 0xFFFF in free-run mode. A level interrupt output follows the flag while interrupts are enabled.

Software starts the timer by setting the enable bit. It acknowledges an interrupt by writing one to the flag position, or by writing a new modulus. When the overwrite bit is set, a modulus write also places the new value in the live counter at once. A write that touches only the interrupt-enable or flag bits leaves the timing untouched. This lets software acknowledge interrupts without losing phase.

Top module: `pit_timer`

## Requirements
- R1: After reset the control and modulus registers read 0x0000, the count register reads 0xFFFF, and irq is low.
- R2: A write to byte offset 0x0 targets control/status, 0x2 targets modulus, and 0x4 reads the live count. A write to 0x4 has no effect. Control bit positions: 0 enable, 1 reload, 2 flag, 3 interrupt enable, 4 overwrite, 5 debug, 6 doze, 11:8 prescale select. All other control bits read as zero, and any other offset reads 0x0000.
- R3: While enabled, the counter steps once every 2 × 2^PRE clock cycles, where PRE is the prescale select.
- R4: irq is high exactly while both the flag and the interrupt-enable bit are set.
- R5: Writing 1 to control bit 2 clears the flag. Writing 0 there leaves the flag as it is. Only a countdown step from zero sets the flag.
- R6: In reload mode, a step from zero sets the flag and loads the counter with the modulus value.
- R7: In free-run mode, a step from zero sets the flag and loads the counter with 0xFFFF.
- R8: Every modulus write clears the flag.
- R9: A modulus write while overwrite is set loads the written value into the counter on the next edge. While overwrite is clear, the counter keeps counting and the new modulus is used only at the next reload.
- R10: A control write whose only changes are to the interrupt-enable or flag bits leaves the prescale phase and the counter undisturbed. Any other change restarts the prescale phase.
- R11: While enable is low, the counter and prescale phase hold. A control write that raises enable loads the counter with the reload value: the modulus in reload mode, 0xFFFF otherwise.
- R12: When a countdown step from zero falls in the same cycle as a flag-clearing write, the flag ends up set.
- R13: The debug and doze bits are stored and read back, but they do not change counting or interrupts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Byte offset of the accessed register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the register at addr (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The flag can be set by a countdown step from zero in the same cycle that software clears it. The clear may come from writing one to control bit 2 or from a modulus write. The bench provokes this by issuing flag-clearing control writes on every cycle while the counter runs with a short modulus and no prescaling, so a wrap is certain to land under one of them. A behavioural model in the bench lets the set win. It compares irq and the flag read-back on every clock, so losing the event or clearing it late shows up as a mismatch.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int REG_W = 16;
    localparam int PRE_W = 4;

    // Bit positions of the control/status word (decoded by software)
    localparam int B_EN   = 0;
    localparam int B_RLD  = 1;
    localparam int B_FLAG = 2;
    localparam int B_IE   = 3;
    localparam int B_OVW  = 4;
    localparam int B_DBG  = 5;
    localparam int B_DOZE = 6;
    localparam int B_PRE  = 8;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             doze;
        logic             dbg;
        logic             ovw;
        logic             ie;
        logic             rld;
        logic             en;
    } ctrl_t;

    function automatic logic [REG_W-1:0] ctrl_word(ctrl_t c, logic flag);
        logic [REG_W-1:0] w;
        w                      = '0;
        w[B_EN]                = c.en;
        w[B_RLD]               = c.rld;
        w[B_FLAG]              = flag;
        w[B_IE]                = c.ie;
        w[B_OVW]               = c.ovw;
        w[B_DBG]               = c.dbg;
        w[B_DOZE]              = c.doze;
        w[B_PRE+PRE_W-1:B_PRE] = c.pre;
        return w;
    endfunction

    function automatic ctrl_t ctrl_from_word(logic [REG_W-1:0] w);
        ctrl_t c;
        c.en   = w[B_EN];
        c.rld  = w[B_RLD];
        c.ie   = w[B_IE];
        c.ovw  = w[B_OVW];
        c.dbg  = w[B_DBG];
        c.doze = w[B_DOZE];
        c.pre  = w[B_PRE+PRE_W-1:B_PRE];
        return c;
    endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int SEL_W = pit_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int DIV_W = 2 ** SEL_W;

    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [DIV_W:0]   limit_wide;
    logic [DIV_W-1:0] limit;

    // Period is 2 * 2^sel cycles: divide by two, then by the selected power
    assign limit_wide = ((DIV_W + 1)'(2) << sel_i) - (DIV_W + 1)'(1);
    assign limit      = limit_wide[DIV_W-1:0];
    assign tick_o     = run_i && !restart_i && (st_q.phase == limit);

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.phase = '0;
        end else if (run_i) begin
            if (tick_o) st_d.phase = '0;
            else        st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i) |=> $stable(st_q.phase)); // R11

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (st_q.phase == '0)); // R10

endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
    parameter int DATA_W = pit_pkg::REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              reload_mode_i,
    input  logic [DATA_W-1:0] modulus_i,
    output logic [DATA_W-1:0] count_o,
    output logic              wrap_o
);
    typedef struct packed {
        logic [DATA_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    assign wrap_o  = tick_i && (st_q.count == '0);
    assign count_o = st_q.count;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.count = load_val_i;
        end else if (tick_i) begin
            if (st_q.count == '0) st_d.count = reload_mode_i ? modulus_i : '1;
            else                  st_d.count = st_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && st_q.count != '0) |=> (st_q.count == $past(st_q.count) - 1'b1)); // R3

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(st_q.count)); // R11

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.count == $past(load_val_i))); // R9

    AST_CNT_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !load_i && !reload_mode_i) |=> (st_q.count == '1)); // R7

endmodule

// File: rtl/pit_regs.sv
module pit_regs #(
    parameter int              DATA_W   = pit_pkg::REG_W,
    parameter int              ADDR_W   = 3,
    parameter logic [ADDR_W-1:0] OFS_CTRL = 3'd0,
    parameter logic [ADDR_W-1:0] OFS_MOD  = 3'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wrap_i,
    output pit_pkg::ctrl_t    ctrl_o,
    output logic              flag_o,
    output logic [DATA_W-1:0] modulus_o,
    output logic              restart_o,
    output logic              load_o,
    output logic [DATA_W-1:0] load_val_o,
    output logic              irq_o
);
    import pit_pkg::*;

    typedef struct packed {
        ctrl_t             ctrl;
        logic              flag;
        logic [DATA_W-1:0] modulus;
    } reg_state_t;

    reg_state_t st_d, st_q;
    ctrl_t      wr_ctrl;
    logic       sel_ctrl, sel_mod, cfg_changed, start, flag_clr;

    assign sel_ctrl = wr_en_i && (addr_i == OFS_CTRL);
    assign sel_mod  = wr_en_i && (addr_i == OFS_MOD);
    assign wr_ctrl  = ctrl_from_word(wdata_i[REG_W-1:0]);

    // Interrupt-enable is excluded: toggling it must not disturb timing
    assign cfg_changed = {wr_ctrl.pre, wr_ctrl.doze, wr_ctrl.dbg, wr_ctrl.ovw, wr_ctrl.rld, wr_ctrl.en}
                      != {st_q.ctrl.pre, st_q.ctrl.doze, st_q.ctrl.dbg, st_q.ctrl.ovw,
                          st_q.ctrl.rld, st_q.ctrl.en};
    assign restart_o = sel_ctrl && cfg_changed;
    assign start     = restart_o && wr_ctrl.en && !st_q.ctrl.en;
    assign load_o    = start || (sel_mod && st_q.ctrl.ovw);
    assign load_val_o = start ? (wr_ctrl.rld ? st_q.modulus : '1) : wdata_i;
    assign flag_clr  = (sel_ctrl && wdata_i[B_FLAG]) || sel_mod;

    always_comb begin
        st_d = st_q;
        if (sel_ctrl) st_d.ctrl    = wr_ctrl;
        if (sel_mod)  st_d.modulus = wdata_i;
        if (wrap_i)        st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o    = st_q.ctrl;
    assign flag_o    = st_q.flag;
    assign modulus_o = st_q.modulus;
    assign irq_o     = st_q.flag && st_q.ctrl.ie;

    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> st_q.flag); // R12

    AST_FLAG_ONLY_HW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(wrap_i)); // R5

    AST_MOD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_mod && !wrap_i) |=> !st_q.flag); // R8

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ctrl && !wdata_i[B_IE]) |=> !irq_o); // R4

endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
    parameter int DATA_W = pit_pkg::REG_W,
    parameter int SEL_W  = pit_pkg::PRE_W,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    import pit_pkg::*;

    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_MOD  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'(4);

    ctrl_t             ctrl;
    logic              flag, restart, load, tick, wrap;
    logic [DATA_W-1:0] modulus, load_val, count;

    pit_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_CTRL(OFS_CTRL), .OFS_MOD(OFS_MOD)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wr_data),
        .wrap_i(wrap), .ctrl_o(ctrl), .flag_o(flag), .modulus_o(modulus),
        .restart_o(restart), .load_o(load), .load_val_o(load_val), .irq_o(irq)
    );

    pit_prescaler #(.SEL_W(SEL_W)) i_pre (
        .clk(clk), .rst_n(rst_n), .run_i(ctrl.en), .restart_i(restart),
        .sel_i(ctrl.pre), .tick_o(tick)
    );

    pit_counter #(.DATA_W(DATA_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(load), .load_val_i(load_val),
        .reload_mode_i(ctrl.rld), .modulus_i(modulus), .count_o(count), .wrap_o(wrap)
    );

    always_comb begin
        case (addr)
            OFS_CTRL: rd_data = ctrl_word(ctrl, flag);
            OFS_MOD:  rd_data = modulus;
            OFS_CNT:  rd_data = count;
            default:  rd_data = '0;
        endcase
    end

    AST_CNT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CNT && !tick && !load) |=> $stable(count)); // R2

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en) |-> !wrap); // R11

endmodule

// File: tb/test_pit_timer.sv
module test_pit_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic        irq;

    int vectors = 0;
    int fails   = 0;
    string tag  = "R1";

    // behavioural reference state
    int m_ctrl = 0, m_mod = 0, m_cnt = 16'hFFFF, m_flag = 0, m_phase = 0;

    always #10 clk = ~clk;

    pit_timer i_pit_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    function automatic int model_rd(int a);
        case (a)
            0: return m_ctrl | (m_flag << 2);
            2: return m_mod;
            4: return m_cnt;
            default: return 0;
        endcase
    endfunction

    task automatic model_step(bit w, int a, int d);
        int  pre, lim, n_ctrl, n_mod, n_cnt, n_flag, n_phase;
        bit  en, rld, ovw, wc, wm, restart, tick, wrap, start;
        en  = m_ctrl[0]; rld = m_ctrl[1]; ovw = m_ctrl[4];
        pre = (m_ctrl >> 8) & 15;
        lim = (2 << pre) - 1;
        wc  = w && a == 0;
        wm  = w && a == 2;
        restart = wc && (((m_ctrl ^ (d & 16'h0F7B)) & 16'h0F73) != 0);
        start   = restart && d[0] && !en;
        tick    = en && !restart && m_phase == lim;
        wrap    = tick && m_cnt == 0;
        n_phase = restart ? 0 : (en ? (tick ? 0 : m_phase + 1) : m_phase);
        n_cnt   = m_cnt;
        if (start)        n_cnt = d[1] ? m_mod : 16'hFFFF;
        else if (wm && ovw) n_cnt = d;
        else if (tick)    n_cnt = (m_cnt == 0) ? (rld ? m_mod : 16'hFFFF) : m_cnt - 1;
        n_flag = m_flag;
        if (wrap) n_flag = 1;
        else if ((wc && d[2]) || wm) n_flag = 0;
        n_ctrl = wc ? (d & 16'h0F7B) : m_ctrl;
        n_mod  = wm ? d : m_mod;
        m_ctrl = n_ctrl; m_mod = n_mod; m_cnt = n_cnt; m_flag = n_flag; m_phase = n_phase;
    endtask

    task automatic compare();
        int exp_rd, exp_irq;
        exp_rd  = model_rd(int'(addr));
        exp_irq = m_flag & m_ctrl[3];
        vectors++;
        if (int'(rd_data) != exp_rd) begin
            fails++;
            $display("FAIL %s rd_data addr=%0d actual=%h expected=%h", tag, addr, rd_data, exp_rd[15:0]);
        end
        vectors++;
        if (int'(irq) != exp_irq) begin
            fails++;
            $display("FAIL %s irq actual=%0d expected=%0d", tag, irq, exp_irq);
        end
    endtask

    // one clock: drive, model the edge, sample at the falling edge
    task automatic cyc(bit w, int a, int d);
        wr_en = w; addr = 3'(a); wr_data = 16'(d);
        @(posedge clk);
        model_step(w, a, d);
        @(negedge clk);
        compare();
    endtask

    task automatic wr(int a, int d);
        cyc(1'b1, a, d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, (i % 3 == 2) ? 0 : 4, 0);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        compare();
        rst_n = 1'b1;
        cyc(0, 0, 0); cyc(0, 2, 0); cyc(0, 4, 0); cyc(0, 6, 0);

        tag = "R2";
        wr(0, 16'hF3E0);          // debug, doze, pre=3, reserved bits dropped, en=0
        cyc(0, 0, 0);
        wr(4, 16'h1234);          // count is read-only
        cyc(0, 4, 0);
        wr(2, 16'h00AB);
        cyc(0, 2, 0);

        tag = "R11";
        idle(12);                 // disabled: everything holds
        tag = "R9";
        wr(0, 16'h0000);
        wr(2, 16'h0005);          // overwrite clear: count stays
        cyc(0, 4, 0);

        tag = "R6";
        wr(0, 16'h000B);          // en, reload, ie, pre=0 -> loads 5
        idle(30);
        tag = "R4";
        wr(0, 16'h0003);          // ie off: irq low, flag kept
        idle(4);
        wr(0, 16'h000B);
        idle(3);

        tag = "R5";
        wr(0, 16'h000B);          // writing 0 to flag: no change
        cyc(0, 0, 0);
        wr(0, 16'h000F);          // write-one clears
        cyc(0, 0, 0);

        tag = "R10";
        for (int i = 0; i < 20; i++) wr(0, (i % 2) ? 16'h0003 : 16'h000B);
        idle(6);

        tag = "R12";
        for (int i = 0; i < 40; i++) wr(0, 16'h000F);
        idle(4);

        tag = "R8";
        idle(12);
        wr(2, 16'h0005);
        cyc(0, 0, 0);

        tag = "R9";
        wr(0, 16'h001B);          // overwrite on: restarts prescale only
        wr(2, 16'h0003);          // loads counter at once
        idle(14);

        tag = "R7";
        wr(0, 16'h0019);          // free-run
        wr(2, 16'h0004);
        idle(20);

        tag = "R3";
        wr(0, 16'h0319);          // pre=3 -> 16 cycles per step
        idle(100);
        wr(0, 16'h0119);
        idle(30);

        tag = "R11";
        wr(0, 16'h0118);          // disable
        idle(20);
        wr(0, 16'h0119);          // enable in free-run: loads 0xFFFF
        idle(10);
        wr(0, 16'h0018);
        wr(2, 16'h0002);
        wr(0, 16'h001B);          // enable in reload: loads modulus
        idle(12);

        tag = "R13";
        wr(0, 16'h006B);          // debug + doze set, still counts
        wr(2, 16'h0004);
        idle(30);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule